// File: doc/BRIEF.md
# Cascadable Priority Interrupt Controller

The block collects eight level-sensed interrupt requests, holds them in a request register and filters them through a mask. It resolves a fixed priority, with input 0 highest, against the set of interrupts already being serviced and raises `int_out` toward a processor. The processor answers with a one-cycle acknowledge. In that same cycle the block returns an 8-bit vector, and at the clock edge that ends the cycle it records the winning input as in service. The processor later clears that record with a specific end-of-interrupt command, unless auto end-of-interrupt mode is on.

Software reaches the block through a byte-wide register bus with one address bit. Address 0 is the command port and address 1 is the data port. A command byte with bit 4 set restarts the block and opens a fixed sequence of data-port writes that program the vector base, the cascade word and an optional mode word.

A strap pin picks the master or slave role. A master asserts a 3-bit cascade select while a slave-attached input is being acknowledged. Only the slave whose ID matches that select answers with its vector. The same instance serves in either role, and two instances form a 15-input pair.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask register reads 0xFF and `int_out` stays low, whatever the inputs do, until the initialization sequence has completed.
- R2: A command-port write with bit 4 set clears the mask, the in-service register, auto mode and the read select (which then selects the request register). The next data-port writes are taken in this order: the vector base, the cascade word, and then, only when bit 0 of the command byte was 1, the mode word. After that, data-port writes load the mask.
- R3: The delivered vector is {base[7:3], n}, where n is the index of the lowest-numbered unmasked pending input. Input 0 has the highest priority.
- R4: Mask bit n set to 1 stops input n from raising `int_out`.
- R5: `int_out` is high only when the winning unmasked request has a strictly lower index than every set in-service bit.
- R6: A normal acknowledge sets in-service bit n. A command byte 0x60|n clears in-service bit n.
- R7: With mode-word bit 1 set (auto mode), an acknowledge sets no in-service bit.
- R8: Command 0x0A makes command-port reads return the request register, and 0x0B makes them return the in-service register. The choice holds until it is changed. Data-port reads return the mask.
- R9: An acknowledge with no valid request returns {base[7:3], 7} and sets no in-service bit, even when input 7 is masked.
- R10: On a master, when the winning input has its bit set in the cascade word, the acknowledge drives that input number on `cas_out` with `cas_drive` high, and the master gives no vector. A slave whose ID (cascade word bits 2:0) equals a valid `cas_in` returns its vector. Each side sets its own in-service bit and needs its own end-of-interrupt.
- R11: When an acknowledge and an end-of-interrupt fall in the same cycle, the clear is applied first and the acknowledge's set after it, so the set wins on the same bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 = command port, 1 = data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed port |
| irq_in | input | NIN | Level-sensed requests |
| is_master | input | 1 | Role strap, 1 = master |
| int_out | output | 1 | Interrupt to processor |
| inta | input | 1 | One-cycle acknowledge |
| vec_out | output | 8 | Vector, valid while vec_valid |
| vec_valid | output | 1 | This instance drives the vector |
| cas_in | input | 3 | Cascade select from a master |
| cas_valid_in | input | 1 | Master is driving cas_in |
| cas_out | output | 3 | Cascade select toward slaves |
| cas_drive | output | 1 | cas_out is valid |

## Verification
An acknowledge and a specific end-of-interrupt write can fall in the same cycle, and both change the in-service register at the same edge. The bench raises `inta` and a command write of 0x60|n together. It does this once with n on a bit already in service while a different input wins, and once with n equal to the winning input. It then reads the in-service register back through the 0x0B read select and expects the cleared bit gone and the acknowledged bit present, including when the two are the same bit.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NIN = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr,
  input  logic           bus_addr,
  input  logic [7:0]     bus_wdata,
  output logic [7:0]     bus_rdata,
  input  logic [NIN-1:0] irq_in,
  input  logic           is_master,
  output logic           int_out,
  input  logic           inta,
  output logic [7:0]     vec_out,
  output logic           vec_valid,
  input  logic [2:0]     cas_in,
  input  logic           cas_valid_in,
  output logic [2:0]     cas_out,
  output logic           cas_drive
);
  localparam int IW = $clog2(NIN);

  typedef enum logic [2:0] {S_IDLE, S_BASE, S_CASC, S_MODE, S_RUN} st_t;

  st_t            st;
  logic [NIN-1:0] irr, imr, isr;
  logic [7:0]     base, casw;
  logic           want_mode, aeoi, rd_isr;

  function automatic logic [IW-1:0] first_set(input logic [NIN-1:0] v);
    first_set = IW'(NIN - 1);
    for (int i = NIN - 1; i >= 0; i--)
      if (v[i]) first_set = IW'(i);
  endfunction

  wire            cmd_wr   = bus_wr && !bus_addr;
  wire            dat_wr   = bus_wr && bus_addr;
  wire            init_cmd = cmd_wr && bus_wdata[4];
  wire            eoi_cmd  = cmd_wr && (bus_wdata[7:3] == 5'b01100);
  wire [NIN-1:0]  pend     = irr & ~imr;
  wire [IW-1:0]   win      = first_set(pend);
  wire [IW-1:0]   top_svc  = first_set(isr);
  wire            int_raw  = (st == S_RUN) && (|pend) && ((isr == '0) || (win < top_svc));
  wire            to_slave = is_master && int_raw && casw[win];
  wire            picked   = is_master || (cas_valid_in && cas_in == casw[2:0]);
  wire            do_set   = inta && picked && int_raw && !aeoi;
  wire [NIN-1:0]  set_bits = do_set ? (NIN'(1) << win) : '0;
  wire [NIN-1:0]  clr_bits = eoi_cmd ? (NIN'(1) << bus_wdata[IW-1:0]) : '0;

  assign int_out   = int_raw;
  assign cas_drive = inta && to_slave;
  assign cas_out   = cas_drive ? 3'(win) : 3'd0;
  assign vec_valid = inta && picked && !to_slave;
  assign vec_out   = vec_valid ? {base[7:IW], int_raw ? win : IW'(NIN - 1)} : 8'h00;
  assign bus_rdata = bus_addr ? 8'(imr) : 8'(rd_isr ? isr : irr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr <= '0;
      isr <= '0;
    end else begin
      irr <= irq_in;
      isr <= init_cmd ? '0 : ((isr & ~clr_bits) | set_bits);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      imr       <= '1;
      base      <= 8'h00;
      casw      <= 8'h00;
      want_mode <= 1'b0;
      aeoi      <= 1'b0;
      rd_isr    <= 1'b0;
    end else if (init_cmd) begin
      st        <= S_BASE;
      imr       <= '0;
      want_mode <= bus_wdata[0];
      aeoi      <= 1'b0;
      rd_isr    <= 1'b0;
    end else if (dat_wr) begin
      case (st)
        S_BASE: begin base <= bus_wdata; st <= S_CASC; end
        S_CASC: begin casw <= bus_wdata; st <= want_mode ? S_MODE : S_RUN; end
        S_MODE: begin aeoi <= bus_wdata[1]; st <= S_RUN; end
        default: imr <= bus_wdata[NIN-1:0];
      endcase
    end else if (cmd_wr) begin
      if (bus_wdata == 8'h0A) rd_isr <= 1'b0;
      else if (bus_wdata == 8'h0B) rd_isr <= 1'b1;
    end
  end

  // R1
  ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_RUN) |-> !int_out);

  // R2
  init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_cmd |=> (imr == '0 && isr == '0 && !rd_isr));

  // R6
  eoi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_cmd && !inta) |=> !isr[$past(bus_wdata[IW-1:0])]);

  // R6
  ack_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && is_master && int_out && !aeoi && !bus_wr) |=> isr[$past(win)]);

  // R7
  auto_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && aeoi && !bus_wr) |=> $stable(isr));

  // R9
  spurious_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && !int_out && !bus_wr) |=> $stable(isr));

  // R10
  cas_role_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cas_drive |-> (is_master && !vec_valid));
endmodule

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, m_wr, s_wr, bus_addr, inta;
  logic [7:0] bus_wdata, m_rdata, s_rdata, m_irq, s_irq;
  logic [7:0] m_vec, s_vec;
  logic       m_int, s_int, m_vv, s_vv, m_cd, s_cd;
  logic [2:0] m_co, s_co;
  int nchk = 0, nerr = 0;
  bit done = 0;

  prio_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(m_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(m_rdata),
    .irq_in({m_irq[7:3], s_int, m_irq[1:0]}), .is_master(1'b1),
    .int_out(m_int), .inta(inta), .vec_out(m_vec), .vec_valid(m_vv),
    .cas_in(3'd0), .cas_valid_in(1'b0), .cas_out(m_co), .cas_drive(m_cd));

  prio_irq_ctrl slv (
    .clk(clk), .rst_n(rst_n), .bus_wr(s_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(s_rdata), .irq_in(s_irq),
    .is_master(1'b0), .int_out(s_int), .inta(inta), .vec_out(s_vec),
    .vec_valid(s_vv), .cas_in(m_co), .cas_valid_in(m_cd),
    .cas_out(s_co), .cas_drive(s_cd));

  // {irq, mask, expect_int, expect_vector}; master base 0x20, input 2 is the slave
  localparam logic [24:0] TBL [8] = '{
    {8'h01, 8'h00, 1'b1, 8'h20},
    {8'h88, 8'h00, 1'b1, 8'h23},
    {8'h80, 8'h00, 1'b1, 8'h27},
    {8'hF0, 8'h10, 1'b1, 8'h25},
    {8'h03, 8'h01, 1'b1, 8'h21},
    {8'h41, 8'h41, 1'b0, 8'h00},
    {8'hC0, 8'h00, 1'b1, 8'h26},
    {8'h08, 8'hF7, 1'b1, 8'h23}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sl, input logic a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d;
    if (sl) s_wr = 1'b1; else m_wr = 1'b1;
    @(negedge clk);
    m_wr = 1'b0; s_wr = 1'b0;
  endtask

  task automatic rd(input logic sl, input logic a, output logic [7:0] d);
    bus_addr = a; #1;
    d = sl ? s_rdata : m_rdata;
  endtask

  task automatic ack(output logic [7:0] v, output logic mv, output logic sv);
    inta = 1'b1; #1;
    mv = m_vv; sv = s_vv; v = m_vv ? m_vec : s_vec;
    @(negedge clk);
    inta = 1'b0;
  endtask

  task automatic ack_eoi(input logic [7:0] cmd, output logic [7:0] v);
    inta = 1'b1; m_wr = 1'b1; bus_addr = 1'b0; bus_wdata = cmd; #1;
    v = m_vec;
    @(negedge clk);
    inta = 1'b0; m_wr = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, r;
    logic mv, sv;
    rst_n = 0; m_wr = 0; s_wr = 0; bus_addr = 0; bus_wdata = 0;
    inta = 0; m_irq = 0; s_irq = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    m_irq = 8'h01; @(negedge clk);
    check("R1 int before init", {7'd0, m_int}, 8'h00);
    rd(0, 1, r); check("R1 reset mask", r, 8'hFF);

    wr(0, 0, 8'h11); wr(0, 1, 8'h20); wr(0, 1, 8'h04);
    check("R1 int during init", {7'd0, m_int}, 8'h00);
    wr(0, 1, 8'h01);
    m_irq = 8'h00; @(negedge clk);
    rd(0, 1, r); check("R2 mask cleared", r, 8'h00);

    for (int i = 0; i < 8; i++) begin
      wr(0, 1, TBL[i][16:9]);
      m_irq = TBL[i][24:17];
      @(negedge clk);
      check($sformatf("R4 R5 int row %0d", i), {7'd0, m_int}, {7'd0, TBL[i][8]});
      if (TBL[i][8]) begin
        ack(v, mv, sv);
        check($sformatf("R3 vector row %0d", i), v, TBL[i][7:0]);
        wr(0, 0, 8'h60 | {5'd0, TBL[i][2:0]});
      end
      m_irq = 8'h00; @(negedge clk);
    end

    wr(0, 1, 8'h00);
    m_irq = 8'h02; @(negedge clk); ack(v, mv, sv);
    m_irq = 8'h0A; @(negedge clk);
    check("R5 equal priority blocked", {7'd0, m_int}, 8'h00);
    m_irq = 8'h01; @(negedge clk);
    check("R5 higher priority passes", {7'd0, m_int}, 8'h01);
    ack(v, mv, sv); check("R3 nested vector", v, 8'h20);
    wr(0, 0, 8'h0B); rd(0, 0, r); check("R6 R8 isr two set", r, 8'h03);
    wr(0, 0, 8'h60); rd(0, 0, r); check("R6 eoi bit0", r, 8'h02);
    wr(0, 0, 8'h61); rd(0, 0, r); check("R6 eoi bit1", r, 8'h00);
    wr(0, 0, 8'h0A); m_irq = 8'h90; @(negedge clk);
    rd(0, 0, r); check("R8 request read", r, 8'h90);
    wr(0, 1, 8'h33); rd(0, 1, r); check("R8 mask read", r, 8'h33);
    m_irq = 8'h00; @(negedge clk);

    wr(0, 1, 8'h80);
    m_irq = 8'h10; @(negedge clk);
    check("R9 int raised", {7'd0, m_int}, 8'h01);
    m_irq = 8'h00; @(negedge clk);
    ack(v, mv, sv); check("R9 spurious vector", v, 8'h27);
    wr(0, 0, 8'h0B); rd(0, 0, r); check("R9 no isr", r, 8'h00);

    wr(0, 1, 8'h00);
    m_irq = 8'h08; @(negedge clk); ack(v, mv, sv);
    m_irq = 8'h01; @(negedge clk);
    ack_eoi(8'h63, v); check("R11 vector", v, 8'h20);
    rd(0, 0, r); check("R11 clear other bit", r, 8'h01);
    wr(0, 0, 8'h60); #1;
    ack_eoi(8'h60, v);
    rd(0, 0, r); check("R11 set wins same bit", r, 8'h01);
    wr(0, 0, 8'h60);
    m_irq = 8'h00; @(negedge clk);

    wr(1, 0, 8'h11); wr(1, 1, 8'h28); wr(1, 1, 8'h02); wr(1, 1, 8'h01);
    s_irq = 8'h20; @(negedge clk); @(negedge clk);
    check("R10 master int via slave", {7'd0, m_int}, 8'h01);
    ack(v, mv, sv);
    check("R10 slave vector", v, 8'h2D);
    check("R10 master silent", {6'd0, mv, sv}, 8'h01);
    rd(0, 0, r); check("R10 master isr", r, 8'h04);
    wr(1, 0, 8'h0B); rd(1, 0, r); check("R10 slave isr", r, 8'h20);
    wr(1, 0, 8'h65); rd(1, 0, r); check("R10 slave eoi", r, 8'h00);
    rd(0, 0, r); check("R10 master keeps cascade bit", r, 8'h04);
    wr(0, 0, 8'h62); rd(0, 0, r); check("R10 master eoi", r, 8'h00);
    s_irq = 8'h00; @(negedge clk); @(negedge clk);

    wr(0, 0, 8'h11); wr(0, 1, 8'h20); wr(0, 1, 8'h04); wr(0, 1, 8'h03);
    m_irq = 8'h02; @(negedge clk);
    ack(v, mv, sv); check("R7 auto vector", v, 8'h21);
    wr(0, 0, 8'h0B); rd(0, 0, r); check("R7 auto no isr", r, 8'h00);
    m_irq = 8'h00; @(negedge clk);

    wr(0, 0, 8'h10); wr(0, 1, 8'h20); wr(0, 1, 8'h04); wr(0, 1, 8'h5A);
    rd(0, 1, r); check("R2 no mode word, mask loaded", r, 8'h5A);
    m_irq = 8'h01; @(negedge clk);
    ack(v, mv, sv); check("R2 vector after short init", v, 8'h20);
    wr(0, 0, 8'h0B); rd(0, 0, r); check("R2 R7 auto cleared", r, 8'h01);
    m_irq = 8'h00;

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule